// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up one general-purpose input before it is reported as pin status. The raw pin first passes through a synchronizer. It is then filtered against a slow time base: a real-time-clock tick enable that pulses once per RTC period. Each pin carries its own setting, made of a filter policy, a unit selector and a 4-bit count. The settling window is the count multiplied by the selected unit, and the unit is a fixed number of RTC ticks.

There are three filter policies. The first rejects short pulses in both directions. The second lets falling edges through at once but holds rising edges until they are stable. The third does the opposite. A fourth setting turns filtering off, and the synchronized pin then goes straight to the output. The setting is written by a register interface that lies outside this block. Whenever the setting changes, the filter starts its window again.

Top module: `gpio_debounce_filter`

## Requirements
- R1: With `db_mode` = 0 the filter is bypassed. A change on `pin_raw` appears on `pin_level` three clock cycles later: two synchronizer stages plus the output register.
- R2: With `db_mode` = 1 the filter rejects pulses in both directions. `pin_level` takes a new level only after the synchronized pin has held that level for the full window. With the tick pulsing every cycle, this is window + 2 cycles after the pin changes.
- R3: With `db_mode` = 2, a falling pin reaches `pin_level` three cycles after the change, as in bypass. A rising pin must stay high for the full window.
- R4: With `db_mode` = 3, a rising pin reaches `pin_level` after three cycles. A falling pin must stay low for the full window.
- R5: `unit_sel` = {large, fine} selects the unit. 0 selects UNIT_T0 ticks, 1 selects UNIT_T1, 2 selects UNIT_T2 and 3 selects UNIT_T3. The defaults are 2, 8, 512 and 2048 RTC periods.
- R6: The window is `db_count` multiplied by the selected unit. A count of 0 while filtering is on behaves as a count of 1. The largest count is 15.
- R7: If the pin returns to the current output level before the window has elapsed, the window starts again from zero. A pulse shorter than the window never reaches `pin_level`.
- R8: A change in any field of the setting reloads the window while a filter policy is active. `pin_level` keeps its value in that cycle, and the new window is then counted in full.
- R9: The window advances only on cycles in which `rtc_tick` is high. While the tick is held low, a pending change never reaches `pin_level`.
- R10: During reset `pin_level` is 0 and stays 0 whatever `pin_raw` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Unsynchronized pin level |
| rtc_tick | input | 1 | One-cycle enable per RTC period |
| db_mode | input | 2 | Filter policy: 0 off, 1 reject both, 2 pass falling, 3 pass rising |
| unit_sel | input | 2 | Unit selector {large, fine} |
| db_count | input | CNT_W | Window length in units |
| pin_level | output | 1 | Filtered pin status |

## Verification
The bench sets the unit parameters to 2, 3, 5 and 7 ticks in place of the defaults, and holds the tick high on most cycles. Every window is then at most 105 cycles long, so an exact edge check fits for every unit and for both the zero count and the largest count. Because the four units are distinct primes, a swapped or miswired selector gives a wrong window that the checks catch.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
    typedef enum logic [1:0] {
        DB_OFF       = 2'd0,
        DB_BOTH      = 2'd1,
        DB_KEEP_LOW  = 2'd2,
        DB_KEEP_HIGH = 2'd3
    } db_mode_e;
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = d;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gdb_prescaler.sv
module gdb_prescaler #(
    parameter int UNIT_T0 = 2,
    parameter int UNIT_T1 = 8,
    parameter int UNIT_T2 = 512,
    parameter int UNIT_T3 = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       unit_pulse
);
    localparam int UMAX01 = (UNIT_T0 > UNIT_T1) ? UNIT_T0 : UNIT_T1;
    localparam int UMAX23 = (UNIT_T2 > UNIT_T3) ? UNIT_T2 : UNIT_T3;
    localparam int UMAX   = (UMAX01 > UMAX23) ? UMAX01 : UMAX23;
    localparam int PW     = $clog2(UMAX + 1);

    logic [PW-1:0] lim;
    logic [PW-1:0] pre_d, pre_q;
    logic          at_end;

    always_comb begin
        case (sel)
            2'd0:    lim = PW'(UNIT_T0);
            2'd1:    lim = PW'(UNIT_T1);
            2'd2:    lim = PW'(UNIT_T2);
            default: lim = PW'(UNIT_T3);
        endcase
        at_end = (pre_q == lim - PW'(1));
        pre_d  = pre_q;
        if (clr)          pre_d = '0;
        else if (tick)    pre_d = at_end ? '0 : pre_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign unit_pulse = !clr && tick && at_end;
endmodule

// File: rtl/gdb_filter.sv
module gdb_filter
    import gdb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_lvl,
    input  logic [1:0]       mode,
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] count,
    input  logic             unit_pulse,
    output logic             pre_clr,
    output logic             cfg_change,
    output logic             level
);
    localparam int CFG_W = 4 + CNT_W;

    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [CFG_W-1:0] cfg;
    } state_t;

    state_t st_d, st_q;
    logic [CFG_W-1:0] cfg_now;
    logic [CNT_W-1:0] last_unit;
    logic             differ, fast;

    always_comb begin
        cfg_now    = {mode, sel, count};
        cfg_change = (cfg_now != st_q.cfg);
        last_unit  = (count == '0) ? '0 : count - CNT_W'(1);
        differ     = (sync_lvl != st_q.out);
        fast       = (mode == DB_KEEP_LOW  && !sync_lvl) ||
                     (mode == DB_KEEP_HIGH &&  sync_lvl);
        pre_clr    = (mode == DB_OFF) || cfg_change || !differ || fast;

        st_d     = st_q;
        st_d.cfg = cfg_now;
        if (mode == DB_OFF) begin
            st_d.out = sync_lvl;
            st_d.cnt = '0;
        end else if (cfg_change || !differ) begin
            st_d.cnt = '0;
        end else if (fast) begin
            st_d.out = sync_lvl;
            st_d.cnt = '0;
        end else if (unit_pulse) begin
            if (st_q.cnt == last_unit) begin
                st_d.out = sync_lvl;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.out;
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int UNIT_T0     = 2,
    parameter int UNIT_T1     = 8,
    parameter int UNIT_T2     = 512,
    parameter int UNIT_T3     = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             rtc_tick,
    input  logic [1:0]       db_mode,
    input  logic [1:0]       unit_sel,
    input  logic [CNT_W-1:0] db_count,
    output logic             pin_level
);
    logic sync_lvl, unit_pulse, pre_clr, cfg_change;

    gdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_lvl)
    );

    gdb_prescaler #(
        .UNIT_T0(UNIT_T0), .UNIT_T1(UNIT_T1),
        .UNIT_T2(UNIT_T2), .UNIT_T3(UNIT_T3)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .tick(rtc_tick),
        .sel(unit_sel), .unit_pulse(unit_pulse)
    );

    gdb_filter #(.CNT_W(CNT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .mode(db_mode),
        .sel(unit_sel), .count(db_count), .unit_pulse(unit_pulse),
        .pre_clr(pre_clr), .cfg_change(cfg_change), .level(pin_level)
    );
endmodule

// File: rtl/gdb_chk.sv
module gdb_chk
    import gdb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] db_mode,
    input logic       sync_lvl,
    input logic       cfg_change,
    input logic       unit_pulse,
    input logic       rtc_tick,
    input logic       pin_level
);
    // R1: bypass follows the synchronized pin one cycle later
    p_bypass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == DB_OFF) |=> (pin_level == $past(sync_lvl)));

    // R2: in reject-both mode the output moves only on a completed unit
    p_both_needs_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == DB_BOTH && !unit_pulse) |=> $stable(pin_level));

    // R3: falling edge passes at once in pass-falling mode
    p_low_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == DB_KEEP_LOW && !cfg_change && !sync_lvl && pin_level) |=> !pin_level);

    // R4: rising edge passes at once in pass-rising mode
    p_high_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == DB_KEEP_HIGH && !cfg_change && sync_lvl && !pin_level) |=> pin_level);

    // R8: a setting change holds the output while filtering
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_change && db_mode != DB_OFF) |=> $stable(pin_level));

    // R9: a unit completes only on an RTC tick
    p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unit_pulse |-> rtc_tick);
endmodule

bind gpio_debounce_filter gdb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .db_mode(db_mode), .sync_lvl(sync_lvl),
    .cfg_change(cfg_change), .unit_pulse(unit_pulse), .rtc_tick(rtc_tick),
    .pin_level(pin_level)
);

// File: tb/gpio_debounce_filter_test.sv
module gpio_debounce_filter_test;
    localparam int U0 = 2, U1 = 3, U2 = 5, U3 = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic       rtc_tick = 1'b1;
    logic [1:0] db_mode = 2'd0;
    logic [1:0] unit_sel = 2'd0;
    logic [3:0] db_count = 4'd0;
    logic       pin_level;

    int   total = 0;
    int   bad = 0;
    logic exp_lvl = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    gpio_debounce_filter #(
        .SYNC_STAGES(2), .CNT_W(4),
        .UNIT_T0(U0), .UNIT_T1(U1), .UNIT_T2(U2), .UNIT_T3(U3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .rtc_tick(rtc_tick),
        .db_mode(db_mode), .unit_sel(unit_sel), .db_count(db_count),
        .pin_level(pin_level)
    );

    function automatic int unit_of(logic [1:0] s);
        case (s)
            2'd0:    return U0;
            2'd1:    return U1;
            2'd2:    return U2;
            default: return U3;
        endcase
    endfunction

    function automatic int window(logic [1:0] s, logic [3:0] n);
        return ((n == 4'd0) ? 1 : int'(n)) * unit_of(s);
    endfunction

    function automatic bit is_fast(logic [1:0] m, logic lvl);
        return (m == 2'd0) || (m == 2'd2 && !lvl) || (m == 2'd3 && lvl);
    endfunction

    task automatic chk(string tag, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: pin_level=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic set_cfg(logic [1:0] m, logic [1:0] s, logic [3:0] n);
        db_mode = m; unit_sel = s; db_count = n;
        cyc(3);
    endtask

    // drive a new level and check the exact cycle it reaches the output
    task automatic transition(string tag, logic lvl);
        int k;
        k = is_fast(db_mode, lvl) ? 3 : window(unit_sel, db_count) + 2;
        pin_raw = lvl;
        cyc(k - 1);
        chk({tag, " before"}, pin_level, exp_lvl);
        cyc(1);
        chk({tag, " at"}, pin_level, lvl);
        exp_lvl = lvl;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R10: reset holds output low
        pin_raw = 1'b1;
        cyc(4);
        chk("R10 in reset", pin_level, 1'b0);
        pin_raw = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R10 after reset", pin_level, 1'b0);

        // R1 bypass
        set_cfg(2'd0, 2'd3, 4'd9);
        transition("R1 bypass rise", 1'b1);
        transition("R1 bypass fall", 1'b0);

        // R2 reject both
        set_cfg(2'd1, 2'd0, 4'd4);
        transition("R2 both rise", 1'b1);
        transition("R2 both fall", 1'b0);

        // R5 every unit
        for (int s = 0; s < 4; s++) begin
            set_cfg(2'd1, 2'(s), 4'd3);
            transition("R5 unit rise", 1'b1);
            transition("R5 unit fall", 1'b0);
        end

        // R6 zero and max count
        set_cfg(2'd1, 2'd2, 4'd0);
        transition("R6 zero count", 1'b1);
        set_cfg(2'd1, 2'd3, 4'd15);
        transition("R6 max count", 1'b0);

        // R3 pass falling
        set_cfg(2'd2, 2'd1, 4'd2);
        transition("R3 slow rise", 1'b1);
        transition("R3 fast fall", 1'b0);

        // R4 pass rising
        set_cfg(2'd3, 2'd1, 4'd2);
        transition("R4 fast rise", 1'b1);
        transition("R4 slow fall", 1'b0);

        // R7 restart after an interrupted window
        set_cfg(2'd1, 2'd1, 4'd4);
        pin_raw = 1'b1;
        cyc(8);
        pin_raw = 1'b0;
        cyc(20);
        chk("R7 short pulse rejected", pin_level, 1'b0);
        transition("R7 full window after restart", 1'b1);

        // R8 setting change reloads the window
        set_cfg(2'd1, 2'd0, 4'd8);
        pin_raw = 1'b0;
        cyc(10);
        db_count = 4'd3;
        cyc(6);
        chk("R8 held after change", pin_level, 1'b1);
        cyc(1);
        chk("R8 new window", pin_level, 1'b0);
        exp_lvl = 1'b0;

        // R9 no tick, no progress
        set_cfg(2'd1, 2'd0, 4'd1);
        rtc_tick = 1'b0;
        pin_raw = 1'b1;
        cyc(20);
        chk("R9 frozen without tick", pin_level, 1'b0);
        rtc_tick = 1'b1;
        cyc(1);
        chk("R9 one tick", pin_level, 1'b0);
        cyc(1);
        chk("R9 two ticks", pin_level, 1'b1);
        exp_lvl = 1'b1;

        // random settings with glitches (R7) and full transitions (R2)
        for (int i = 0; i < 30; i++) begin
            logic [1:0] m, s;
            logic [3:0] n;
            logic       lvl;
            int         w;
            m = 2'(1 + ($urandom % 3));
            s = 2'($urandom % 4);
            n = 4'($urandom % 16);
            set_cfg(m, s, n);
            lvl = ~exp_lvl;
            w = window(s, n);
            if (!is_fast(m, lvl) && w > 1) begin
                int glen;
                glen = 1 + int'($urandom % w) % (w - 1);
                pin_raw = lvl;
                cyc(glen);
                pin_raw = exp_lvl;
                cyc(w + 4);
                chk("R7 random glitch", pin_level, exp_lvl);
            end
            transition("R2 random transition", lvl);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule